// File: doc/BRIEF.md
# IDEA Iterative Cipher Core

This block runs one 64-bit block through the IDEA cipher. It splits the block into four 16-bit lanes and mixes them with three operations: lane XOR, addition modulo 2^16 and multiplication modulo 2^16+1. A single combinational round stage is held in a register loop and is used once per clock for each of the full rounds. After the last round, a separate output-transform stage forms the result.

The block does not hold the key. A key-schedule neighbour watches the `key_idx` output and returns, in the same cycle, the six round subkeys for that index on `subkeys`. Index values 0 to ROUNDS-1 select the full rounds and index ROUNDS selects the output transform. Decryption uses the same datapath. The neighbour then supplies inverted subkeys in reversed order. A `start` pulse loads the block. `done` pulses once when `dout` holds the result.

Top module: `idea_core`

## Requirements
- R1: Lane order: din[63:48] is the first lane X1 and din[15:0] is the fourth lane X4. dout uses the same order.
- R2: Multiplication is modulo 65537. An all-zero operand stands for 65536, and a product equal to 65536 is returned as zero. Blocks and keys made only of zero lanes or only of 0xFFFF lanes give the model result.
- R3: Each full round does the following steps. First it forms mul(X1,K1), add(X2,K2), add(X3,K3) and mul(X4,K4). It XORs results 1 with 3 and results 2 with 4. These two values pass through a multiply-add structure using K5 and K6. Its two outputs are XORed back into the four results. The second and third lanes are swapped at the end of the round. Exactly ROUNDS full rounds are applied. With key 0001..0008 and input 0000000100020003, the result is 11fbed2b01986de5.
- R4: Before the output transform, the round-final swap is undone. The transform is mul(X1,K1), add(X3,K2), add(X2,K3), mul(X4,K4). Because of this, running the datapath with decryption subkeys restores the block.
- R5: subkeys carries K1 in bits [95:80] through K6 in bits [15:0]. During the k-th cycle after start is accepted, key_idx equals k-1, for k = 1 to ROUNDS+1. In the output-transform cycle the lanes K5 and K6 have no effect.
- R6: done is high for exactly one cycle, the (ROUNDS+2)-th cycle after the one in which start is accepted. dout changes only in a cycle where done is high, and it then holds until the next done.
- R7: start is ignored while busy is high. The running block is neither restarted nor replaced, and its timing is unchanged.
- R8: Decrypting a ciphertext gives back the plaintext. The subkeys used are multiplicative inverses of the multiply subkeys and negations of the add subkeys, supplied in reversed round order.
- R9: After reset, busy, done and key_idx are 0 and dout is all zeros. key_idx is 0 whenever busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Load din and begin; ignored while busy |
| din | input | 64 | Input block, X1 in the top lane |
| subkeys | input | 96 | Six subkeys for the current key_idx, K1 on top |
| key_idx | output | 4 | Round index requested from the key schedule |
| busy | output | 1 | A block is being processed |
| done | output | 1 | One-cycle pulse, dout valid |
| dout | output | 64 | Result block, held until the next done |

## Verification
The bench builds the core with its default values: 16-bit lanes and eight rounds, which gives a 4-bit round index. At these values the standard known-answer vector applies, and the bench can derive encryption and decryption subkeys from a 128-bit key with its own rotate schedule and modular inverse. This makes a full encrypt-then-decrypt round trip possible. The corner blocks of all zeros and all ones reach the 65536 encoding of the multiplier on both operands and on the product.

// File: rtl/idea_pkg.sv
package idea_pkg;
  localparam int LANE_W    = 16;
  localparam int LANES     = 4;
  localparam int BLK_W     = LANE_W * LANES;
  localparam int RKEYS     = 6;
  localparam int KEY_BUS_W = LANE_W * RKEYS;
  localparam int OKEY_W    = LANE_W * LANES;

  typedef logic [LANE_W-1:0] lane_t;

  // addition modulo 2^LANE_W
  function automatic lane_t lane_add(input lane_t a, input lane_t b);
    return a + b;
  endfunction

  // multiplication modulo 2^LANE_W+1, zero encodes 2^LANE_W
  // uses lo - hi folding instead of a divider
  function automatic lane_t lane_mul(input lane_t a, input lane_t b);
    logic [LANE_W:0]   ea;
    logic [LANE_W:0]   eb;
    logic [2*LANE_W:0] prod;
    lane_t             lo;
    logic [LANE_W:0]   hi;
    lane_t             diff;
    ea   = (a == '0) ? {1'b1, {LANE_W{1'b0}}} : {1'b0, a};
    eb   = (b == '0) ? {1'b1, {LANE_W{1'b0}}} : {1'b0, b};
    prod = {{LANE_W{1'b0}}, ea} * {{LANE_W{1'b0}}, eb};
    lo   = prod[LANE_W-1:0];
    hi   = prod[2*LANE_W:LANE_W];
    diff = lo - hi[LANE_W-1:0];
    if ({1'b0, lo} < hi) return diff + lane_t'(1);
    return diff;
  endfunction
endpackage

// File: rtl/idea_round.sv
module idea_round
  import idea_pkg::*;
(
  input  logic [BLK_W-1:0]     blk_in,
  input  logic [KEY_BUS_W-1:0] rkeys,
  output logic [BLK_W-1:0]     blk_out
);
  lane_t x [LANES];
  lane_t k [RKEYS];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign x[i] = blk_in[BLK_W-1-i*LANE_W -: LANE_W];
  end
  for (genvar j = 0; j < RKEYS; j++) begin : g_key
    assign k[j] = rkeys[KEY_BUS_W-1-j*LANE_W -: LANE_W];
  end

  lane_t s1, s2, s3, s4;
  lane_t ma_a, ma_b, ma_t, ma_hi, ma_lo;

  always_comb begin
    s1    = lane_mul(x[0], k[0]);
    s2    = lane_add(x[1], k[1]);
    s3    = lane_add(x[2], k[2]);
    s4    = lane_mul(x[3], k[3]);
    ma_a  = s1 ^ s3;
    ma_b  = s2 ^ s4;
    ma_t  = lane_mul(ma_a, k[4]);
    ma_hi = lane_mul(lane_add(ma_t, ma_b), k[5]);
    ma_lo = lane_add(ma_t, ma_hi);
    // lanes two and three leave the round exchanged
    blk_out = {s1 ^ ma_hi, s3 ^ ma_hi, s2 ^ ma_lo, s4 ^ ma_lo};
  end
endmodule

// File: rtl/idea_outx.sv
module idea_outx
  import idea_pkg::*;
(
  input  logic [BLK_W-1:0]  blk_in,
  input  logic [OKEY_W-1:0] okeys,
  output logic [BLK_W-1:0]  blk_out
);
  lane_t x [LANES];
  lane_t k [LANES];

  for (genvar i = 0; i < LANES; i++) begin : g_split
    assign x[i] = blk_in[BLK_W-1-i*LANE_W -: LANE_W];
    assign k[i] = okeys[OKEY_W-1-i*LANE_W -: LANE_W];
  end

  // middle lanes re-exchanged before mixing, cancelling the last round's swap
  always_comb
    blk_out = {lane_mul(x[0], k[0]), lane_add(x[2], k[1]),
               lane_add(x[1], k[2]), lane_mul(x[3], k[3])};
endmodule

// File: rtl/idea_seq.sv
module idea_seq #(
  parameter  int ROUNDS = 8,
  localparam int IDX_W  = $clog2(ROUNDS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy,
  output logic [IDX_W-1:0] rnd,
  output logic             accept,
  output logic             round_fire,
  output logic             xform_fire
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ROUNDS);

  assign accept     = start && !busy;
  assign round_fire = busy && (rnd != LAST);
  assign xform_fire = busy && (rnd == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      rnd  <= '0;
    end else if (accept) begin
      busy <= 1'b1;
      rnd  <= '0;
    end else if (round_fire) begin
      rnd  <= rnd + IDX_W'(1);
    end else if (xform_fire) begin
      busy <= 1'b0;
      rnd  <= '0;
    end
  end
endmodule

// File: rtl/idea_core.sv
module idea_core
  import idea_pkg::*;
#(
  parameter  int ROUNDS = 8,
  localparam int IDX_W  = $clog2(ROUNDS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [BLK_W-1:0]     din,
  input  logic [KEY_BUS_W-1:0] subkeys,
  output logic [IDX_W-1:0]     key_idx,
  output logic                 busy,
  output logic                 done,
  output logic [BLK_W-1:0]     dout
);
  logic             accept, round_fire, xform_fire;
  logic [BLK_W-1:0] state_q, round_nxt, xform_nxt;

  idea_seq #(.ROUNDS(ROUNDS)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .busy       (busy),
    .rnd        (key_idx),
    .accept     (accept),
    .round_fire (round_fire),
    .xform_fire (xform_fire)
  );

  idea_round u_round (
    .blk_in  (state_q),
    .rkeys   (subkeys),
    .blk_out (round_nxt)
  );

  idea_outx u_outx (
    .blk_in  (state_q),
    .okeys   (subkeys[KEY_BUS_W-1 -: OKEY_W]),
    .blk_out (xform_nxt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)          state_q <= '0;
    else if (accept)     state_q <= din;
    else if (round_fire) state_q <= round_nxt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done <= 1'b0;
      dout <= '0;
    end else begin
      done <= xform_fire;
      if (xform_fire) dout <= xform_nxt;
    end
  end
endmodule

// File: rtl/idea_core_chk.sv
module idea_core_chk
  import idea_pkg::*;
#(
  parameter  int ROUNDS = 8,
  localparam int IDX_W  = $clog2(ROUNDS + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic [IDX_W-1:0] key_idx,
  input logic [BLK_W-1:0] dout
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ROUNDS);

  p_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && key_idx == '0));

  p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && key_idx != LAST) |=> (busy && key_idx == IDX_W'($past(key_idx) + 1'b1)));

  p_ignore_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && key_idx != LAST) |=> (busy && key_idx != '0));

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_after_xform_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) && $past(key_idx) == LAST && !busy));

  p_dout_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(dout));

  p_idle_index_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> key_idx == '0);
endmodule

bind idea_core idea_core_chk #(.ROUNDS(ROUNDS)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .busy    (busy),
  .done    (done),
  .key_idx (key_idx),
  .dout    (dout)
);

// File: tb/test_idea_core.sv
module test_idea_core;
  localparam int CLK_PERIOD = 10;
  localparam int ROUNDS     = 8;
  localparam int LAT        = ROUNDS + 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [63:0] din = '0;
  logic [95:0] subkeys;
  logic [3:0]  key_idx;
  logic        busy, done;
  logic [63:0] dout;

  int total = 0;
  int bad   = 0;

  logic [15:0] ks [0:8][0:5];   // subkeys currently served
  logic [15:0] ek [0:8][0:5];   // encryption subkeys of the loaded key

  idea_core #(.ROUNDS(ROUNDS)) i_idea_core (
    .clk(clk), .rst_n(rst_n), .start(start), .din(din), .subkeys(subkeys),
    .key_idx(key_idx), .busy(busy), .done(done), .dout(dout)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // key-schedule neighbour: answers the index in the same cycle
  always_comb begin
    if (key_idx <= 4'd8)
      subkeys = {ks[key_idx][0], ks[key_idx][1], ks[key_idx][2],
                 ks[key_idx][3], ks[key_idx][4], ks[key_idx][5]};
    else
      subkeys = '0;
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] m_mul(input logic [15:0] a, input logic [15:0] b);
    longint ua, ub, p;
    ua = (a == 0) ? 65536 : longint'(a);
    ub = (b == 0) ? 65536 : longint'(b);
    p  = (ua * ub) % 65537;
    return (p == 65536) ? 16'h0000 : 16'(p);
  endfunction

  function automatic logic [15:0] m_inv(input logic [15:0] x);
    longint base, r;
    int e;
    base = (x == 0) ? 65536 : longint'(x);
    r = 1;
    e = 65535;
    while (e > 0) begin
      if (e % 2 == 1) r = (r * base) % 65537;
      base = (base * base) % 65537;
      e = e / 2;
    end
    return (r == 65536) ? 16'h0000 : 16'(r);
  endfunction

  // software model of the round equations over the served subkeys
  function automatic logic [63:0] model(input logic [63:0] b);
    logic [15:0] w1, w2, w3, w4, a, bb, c, d, t1, t2, t3;
    {w1, w2, w3, w4} = b;
    for (int r = 0; r < ROUNDS; r++) begin
      a  = m_mul(w1, ks[r][0]);
      bb = w2 + ks[r][1];
      c  = w3 + ks[r][2];
      d  = m_mul(w4, ks[r][3]);
      t1 = m_mul(a ^ c, ks[r][4]);
      t2 = m_mul(16'(t1 + (bb ^ d)), ks[r][5]);
      t3 = t1 + t2;
      w1 = a ^ t2;
      w2 = c ^ t2;
      w3 = bb ^ t3;
      w4 = d ^ t3;
    end
    return {m_mul(w1, ks[8][0]), 16'(w3 + ks[8][1]), 16'(w2 + ks[8][2]), m_mul(w4, ks[8][3])};
  endfunction

  task automatic load_enc(input logic [127:0] key);
    logic [127:0] kk;
    kk = key;
    for (int i = 0; i < 52; i++) begin
      if (i != 0 && i % 8 == 0) kk = {kk[102:0], kk[127:103]};
      ek[i/6][i%6] = kk[127-16*(i%8) -: 16];
    end
    ek[8][4] = 16'h0;
    ek[8][5] = 16'h0;
    for (int r = 0; r < 9; r++)
      for (int j = 0; j < 6; j++) ks[r][j] = ek[r][j];
    ks[8][4] = 16'hdead;
    ks[8][5] = 16'hbeef;
  endtask

  task automatic load_dec();
    for (int r = 0; r < 9; r++) begin
      ks[r][0] = m_inv(ek[8-r][0]);
      ks[r][3] = m_inv(ek[8-r][3]);
      if (r == 0 || r == 8) begin
        ks[r][1] = 16'(0 - ek[8-r][1]);
        ks[r][2] = 16'(0 - ek[8-r][2]);
      end else begin
        ks[r][1] = 16'(0 - ek[8-r][2]);
        ks[r][2] = 16'(0 - ek[8-r][1]);
      end
      if (r < 8) begin
        ks[r][4] = ek[7-r][4];
        ks[r][5] = ek[7-r][5];
      end else begin
        ks[r][4] = 16'h5a5a;
        ks[r][5] = 16'ha5a5;
      end
    end
  endtask

  task automatic run_block(input logic [63:0] blk, input bit inject,
                           output logic [63:0] res, output int lat, output int idx_err);
    idx_err = 0;
    @(negedge clk);
    din   = blk;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat   = 1;
    while (!done && lat < 100) begin
      if (key_idx !== 4'(lat - 1)) idx_err++;
      if (inject && lat == 4) begin
        start = 1'b1;
        din   = ~blk;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      lat++;
    end
    start = 1'b0;
    res   = dout;
  endtask

  task automatic t_reset();
    check("R9 reset dout", dout, 64'h0);
    check("R9 reset flags", {58'h0, busy, done, key_idx}, 64'h0);
  endtask

  task automatic t_known();
    logic [63:0] res;
    int lat, ie;
    load_enc(128'h0001_0002_0003_0004_0005_0006_0007_0008);
    run_block(64'h0000_0001_0002_0003, 1'b0, res, lat, ie);
    check("R3 known answer", res, 64'h11fb_ed2b_0198_6de5);
    check("R1 lane order vs model", res, model(64'h0000_0001_0002_0003));
    check("R6 done latency", 64'(lat), 64'(LAT));
    check("R5 key index sequence errors", 64'(ie), 64'h0);
  endtask

  task automatic t_corners();
    logic [63:0] res;
    int lat, ie;
    load_enc('0);
    run_block(64'h0, 1'b0, res, lat, ie);
    check("R2 zero block zero key", res, model(64'h0));
    load_enc('1);
    run_block('1, 1'b0, res, lat, ie);
    check("R2 ones block ones key", res, model('1));
    load_enc('0);
    run_block('1, 1'b0, res, lat, ie);
    check("R2 ones block zero key", res, model('1));
    load_enc(128'hffff_0000_0001_8000_ffff_0000_0001_8000);
    run_block(64'h0000_ffff_0001_8000, 1'b0, res, lat, ie);
    check("R1 mixed lanes", res, model(64'h0000_ffff_0001_8000));
  endtask

  task automatic t_xform_keys();
    logic [63:0] r1, r2;
    int lat, ie;
    load_enc(128'h2b7e_1516_28ae_d2a6_abf7_1588_09cf_4f3c);
    ks[8][4] = 16'h0000; ks[8][5] = 16'h0000;
    run_block(64'h3243_f6a8_885a_308d, 1'b0, r1, lat, ie);
    ks[8][4] = 16'hffff; ks[8][5] = 16'h1234;
    run_block(64'h3243_f6a8_885a_308d, 1'b0, r2, lat, ie);
    check("R5 unused transform keys", r2, r1);
  endtask

  task automatic t_busy_start();
    logic [63:0] res;
    int lat, ie;
    load_enc(128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210);
    run_block(64'hcafe_f00d_1234_5678, 1'b1, res, lat, ie);
    check("R7 result with start while busy", res, model(64'hcafe_f00d_1234_5678));
    check("R7 latency with start while busy", 64'(lat), 64'(LAT));
  endtask

  task automatic t_decrypt();
    logic [63:0] ct, pt;
    logic [63:0] pts [3];
    int lat, ie;
    pts[0] = 64'h0000_0001_0002_0003;
    pts[1] = 64'hffff_0000_ffff_0000;
    pts[2] = 64'h9e37_79b9_7f4a_7c15;
    for (int i = 0; i < 3; i++) begin
      load_enc(128'h6a09_e667_bb67_ae85_3c6e_f372_a54f_f53a ^ 128'(i));
      run_block(pts[i], 1'b0, ct, lat, ie);
      load_dec();
      run_block(ct, 1'b0, pt, lat, ie);
      check("R8 R4 decrypt round trip", pt, pts[i]);
    end
  endtask

  task automatic t_hold();
    logic [63:0] res;
    int lat, ie;
    load_enc(128'h1);
    run_block(64'h55aa_55aa_0f0f_f0f0, 1'b0, res, lat, ie);
    @(negedge clk);
    check("R6 done one cycle", {63'h0, done}, 64'h0);
    din = 64'h1111_2222_3333_4444;
    for (int i = 0; i < 5; i++) @(negedge clk);
    check("R6 dout held", dout, res);
    check("R9 idle flags", {58'h0, busy, done, key_idx}, 64'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int r = 0; r < 9; r++)
      for (int j = 0; j < 6; j++) ks[r][j] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_known();
    t_corners();
    t_xform_keys();
    t_busy_start();
    t_decrypt();
    t_hold();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule